// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from its module clock. Software programs a divider through a small register port. One control bit picks between two division laws. The power-of-two law divides the module clock by 2^E. The linear law divides it by 2·(N+1). In both laws the serial clock has a 50% duty cycle, because an internal counter reloads on every half-period.

A second register holds the bus controls: bus enable, master select, sample-mode select, transmit pause and a self-clearing soft reset. The serial clock stays at its idle level and no edge strobes appear until bus enable is set. The intended order is to program the divider first and set bus enable last. Writing the divider register restarts the clock from its idle level. This means a new rate never produces a short or stretched half-period.

Alongside SCK, the block gives one-cycle strobes that mark the leading edge (idle to active) and the trailing edge (active to idle). It also gives a sample strobe that follows the leading edge. When sample mode is selected, that strobe comes one module-clock cycle later. These strobes drive the shift and capture logic next to the block. The idle level is an input, so the clock-polarity setting can live elsewhere.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset, SCK equals `sckIdle`, all strobes are low, every mode flag is low and both registers read back as zero.
- R2: Write the clock register (address 1) with bit 12 set and N in bits [7:0]. While the bus is enabled, SCK then has a period of 2·(N+1) module clocks. N=0 gives half the module clock rate and N=255 gives a period of 512 cycles.
- R3: Write the clock register with bit 12 clear and E in bits [11:8]. SCK then has a period of 2^E module clocks. E=0 is treated as 1, and any E above MAX_EXP (10) is treated as MAX_EXP.
- R4: In both modes SCK spends exactly half of each period at its active level.
- R5: While bus enable (control register address 0, bit 0) is clear, SCK stays at `sckIdle` and no strobe fires, whatever the divider holds.
- R6: A write to the clock register restarts the divider. In the second cycle after the write, SCK is at idle and no strobe is high. The next leading edge comes one half-period after that.
- R7: Writing 1 to control bit 31 returns SCK to idle and clears the divider count in the second cycle after the write. The bit reads as 1 for one cycle and then as 0. The other control bits written with it keep their values.
- R8: `sckLead` is high for exactly the one cycle in which SCK has just moved from idle to active. `sckTrail` is high for exactly the one cycle in which SCK has just moved from active to idle. The two are never high together.
- R9: When control bit 2 is clear, `sampleStb` equals `sckLead`. When bit 2 is set, `sampleStb` equals `sckLead` delayed by one module clock.
- R10: The flag outputs follow control bits 0 (bus enable), 1 (master), 2 (sample mode) and 7 (transmit pause). Reads return these bits in the same places, and bit 31 as the soft-reset bit. Reads of the clock register return bits [7:0], [11:8] and 12 as written. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 clock divider |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the selected register |
| sckIdle | input | 1 | Idle level of SCK (clock polarity) |
| sck | output | 1 | Serial clock |
| sckLead | output | 1 | One-cycle strobe on the idle-to-active edge |
| sckTrail | output | 1 | One-cycle strobe on the active-to-idle edge |
| sampleStb | output | 1 | Capture strobe, optionally delayed by one cycle |
| busOn | output | 1 | Bus enable flag |
| masterOn | output | 1 | Master mode flag |
| sampleMode | output | 1 | Delayed sample mode flag |
| txPause | output | 1 | Transmit pause flag |

## Verification
A wrong half-period count shows up at `sck` within one SCK period. The next leading edge arrives early or late, so a per-cycle comparison with a behavioural model catches it at the first misplaced edge. A divider that fails to restart, or a soft reset that fails to clear, leaves SCK away from idle in the second cycle after the write. A stale or wrongly decoded register field shows up at once on `regRdata` or on a flag output. A strobe that does not track the SCK edges differs from the model in the very cycle the edge occurs.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;
  parameter int LIN_W      = 8;
  parameter int EXP_W      = 4;
  parameter int MAX_EXP    = 10;
  parameter int DATA_W     = 32;
  parameter int CNT_W      = ((LIN_W + 1) > MAX_EXP) ? (LIN_W + 1) : MAX_EXP;
  parameter int BIT_EN     = 0;
  parameter int BIT_MST    = 1;
  parameter int BIT_SMP    = 2;
  parameter int BIT_PAUSE  = 7;
  parameter int BIT_SRST   = 31;
  parameter int BIT_SEL    = LIN_W + EXP_W;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_CLK  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic             run;
    logic             restart;
    logic [CNT_W-1:0] halfCount;
  } sck_ctl_t;
endpackage

// File: rtl/sck_gen_regs.sv
module sck_gen_regs
  import sck_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output sck_ctl_t          ctl,
  output logic              busOn,
  output logic              masterOn,
  output logic              sampleMode,
  output logic              txPause
);
  logic             enBit, mstBit, smpBit, pauseBit, srstBit, restartP, selBit;
  logic [LIN_W-1:0] linDiv;
  logic [EXP_W-1:0] expDiv;
  logic [EXP_W-1:0] expEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      mstBit   <= 1'b0;
      smpBit   <= 1'b0;
      pauseBit <= 1'b0;
      srstBit  <= 1'b0;
      restartP <= 1'b0;
      selBit   <= 1'b0;
      linDiv   <= '0;
      expDiv   <= '0;
    end else begin
      srstBit  <= 1'b0;
      restartP <= 1'b0;
      if (regWr) begin
        if (regAddr == ADDR_CTRL) begin
          enBit    <= regWdata[BIT_EN];
          mstBit   <= regWdata[BIT_MST];
          smpBit   <= regWdata[BIT_SMP];
          pauseBit <= regWdata[BIT_PAUSE];
          srstBit  <= regWdata[BIT_SRST];
        end else begin
          linDiv   <= regWdata[LIN_W-1:0];
          expDiv   <= regWdata[LIN_W +: EXP_W];
          selBit   <= regWdata[BIT_SEL];
          restartP <= 1'b1;
        end
      end
    end
  end

  // Clamp the exponent into the supported range [1, MAX_EXP]
  always_comb begin
    if (expDiv == '0)
      expEff = EXP_W'(1);
    else if (expDiv > EXP_W'(MAX_EXP))
      expEff = EXP_W'(MAX_EXP);
    else
      expEff = expDiv;
  end

  always_comb begin
    ctl.run     = enBit && !srstBit;
    ctl.restart = restartP;
    if (selBit)
      ctl.halfCount = CNT_W'(linDiv) + CNT_W'(1);
    else
      ctl.halfCount = CNT_W'(1) << (expEff - EXP_W'(1));
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdata[BIT_EN]    = enBit;
      regRdata[BIT_MST]   = mstBit;
      regRdata[BIT_SMP]   = smpBit;
      regRdata[BIT_PAUSE] = pauseBit;
      regRdata[BIT_SRST]  = srstBit;
    end else begin
      regRdata[LIN_W-1:0]      = linDiv;
      regRdata[LIN_W +: EXP_W] = expDiv;
      regRdata[BIT_SEL]        = selBit;
    end
  end

  assign busOn      = enBit;
  assign masterOn   = mstBit;
  assign sampleMode = smpBit;
  assign txPause    = pauseBit;
endmodule

// File: rtl/sck_gen_core.sv
module sck_gen_core
  import sck_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  sck_ctl_t ctl,
  input  logic     sampleMode,
  input  logic     sckIdle,
  output logic     sck,
  output logic     sckLead,
  output logic     sckTrail,
  output logic     sampleStb
);
  logic [CNT_W-1:0] halfCnt;
  logic             activeQ, leadQ, trailQ, leadDly;
  logic             halfDone;

  assign halfDone = (halfCnt == ctl.halfCount - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      activeQ <= 1'b0;
      leadQ   <= 1'b0;
      trailQ  <= 1'b0;
    end else if (!ctl.run || ctl.restart) begin
      halfCnt <= '0;
      activeQ <= 1'b0;
      leadQ   <= 1'b0;
      trailQ  <= 1'b0;
    end else if (halfDone) begin
      halfCnt <= '0;
      activeQ <= !activeQ;
      leadQ   <= !activeQ;
      trailQ  <= activeQ;
    end else begin
      halfCnt <= halfCnt + CNT_W'(1);
      leadQ   <= 1'b0;
      trailQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) leadDly <= 1'b0;
    else       leadDly <= leadQ;
  end

  assign sck       = activeQ ^ sckIdle;
  assign sckLead   = leadQ;
  assign sckTrail  = trailQ;
  assign sampleStb = sampleMode ? leadDly : leadQ;
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import sck_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sckIdle,
  output logic              sck,
  output logic              sckLead,
  output logic              sckTrail,
  output logic              sampleStb,
  output logic              busOn,
  output logic              masterOn,
  output logic              sampleMode,
  output logic              txPause
);
  sck_ctl_t ctl;

  sck_gen_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .ctl        (ctl),
    .busOn      (busOn),
    .masterOn   (masterOn),
    .sampleMode (sampleMode),
    .txPause    (txPause)
  );

  sck_gen_core u_core (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleMode (sampleMode),
    .sckIdle    (sckIdle),
    .sck        (sck),
    .sckLead    (sckLead),
    .sckTrail   (sckTrail),
    .sampleStb  (sampleStb)
  );
endmodule

// File: rtl/sck_gen_checks.sv
module sck_gen_checks
  import sck_gen_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              sckIdle,
  input logic              sck,
  input logic              sckLead,
  input logic              sckTrail,
  input logic              sampleStb,
  input logic              busOn,
  input logic              sampleMode
);
  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busOn |=> (sck == sckIdle && !sckLead && !sckTrail));

  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(sckLead && sckTrail));

  assert_lead_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    sckLead |=> !sckLead);

  assert_sample_direct_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleMode |-> (sampleStb == sckLead));

  assert_sample_delayed_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sampleMode && $past(sampleMode)) |-> (sampleStb == $past(sckLead)));

  assert_restart_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 1'b1) |=> ##1 (sck == sckIdle && !sckLead && !sckTrail));

  assert_softreset_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 1'b0 && regWdata[BIT_SRST]) |=> ##1 (sck == sckIdle && !sckLead));
endmodule

bind spi_sck_gen sck_gen_checks u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .sckIdle    (sckIdle),
  .sck        (sck),
  .sckLead    (sckLead),
  .sckTrail   (sckTrail),
  .sampleStb  (sampleStb),
  .busOn      (busOn),
  .sampleMode (sampleMode)
);

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sckIdle = 1'b0;
  logic        sck, sckLead, sckTrail, sampleStb, busOn, masterOn, sampleMode, txPause;

  int errors = 0;
  int total  = 0;
  bit modelOn = 1'b0;

  always #4 clk = ~clk;

  spi_sck_gen uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .sckIdle(sckIdle), .sck(sck), .sckLead(sckLead),
    .sckTrail(sckTrail), .sampleStb(sampleStb), .busOn(busOn), .masterOn(masterOn),
    .sampleMode(sampleMode), .txPause(txPause)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit mBus, mMas, mSm, mPause, mSrst, mRst, mSel;
  bit mAct, mLead, mTrail, mLeadD;
  int mCnt, mLin, mExp;

  function automatic int halfOf(bit sel, int lin, int ex);
    int e;
    if (sel) return lin + 1;
    e = (ex < 1) ? 1 : ((ex > 10) ? 10 : ex);
    return 1 << (e - 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBus = 0; mMas = 0; mSm = 0; mPause = 0; mSrst = 0; mRst = 0; mSel = 0;
      mAct = 0; mLead = 0; mTrail = 0; mLeadD = 0; mCnt = 0; mLin = 0; mExp = 0;
    end else begin
      int h;
      bit oldLead;
      h = halfOf(mSel, mLin, mExp);
      oldLead = mLead;
      if (!mBus || mSrst || mRst) begin
        mCnt = 0; mAct = 0; mLead = 0; mTrail = 0;
      end else if (mCnt == h - 1) begin
        mCnt = 0; mLead = !mAct; mTrail = mAct; mAct = !mAct;
      end else begin
        mCnt++; mLead = 0; mTrail = 0;
      end
      mLeadD = oldLead;
      mSrst = 0; mRst = 0;
      if (regWr) begin
        if (!regAddr) begin
          mBus = regWdata[0]; mMas = regWdata[1]; mSm = regWdata[2];
          mPause = regWdata[7]; mSrst = regWdata[31];
        end else begin
          mLin = int'(regWdata[7:0]); mExp = int'(regWdata[11:8]);
          mSel = regWdata[12]; mRst = 1;
        end
      end
    end
  end

  function automatic logic [31:0] mRead(logic a);
    logic [31:0] r = '0;
    if (!a) begin
      r[0] = mBus; r[1] = mMas; r[2] = mSm; r[7] = mPause; r[31] = mSrst;
    end else begin
      r[7:0] = mLin[7:0]; r[11:8] = mExp[3:0]; r[12] = mSel;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    #2;
    if (rstN && modelOn) begin
      chk(sck == (mAct ^ sckIdle), "R4 sck waveform", {31'b0, sck}, {31'b0, mAct ^ sckIdle});
      chk(sckLead == mLead && sckTrail == mTrail, "R8 edge strobes",
          {30'b0, sckLead, sckTrail}, {30'b0, mLead, mTrail});
      chk(sampleStb == (mSm ? mLeadD : mLead), "R9 sample strobe",
          {31'b0, sampleStb}, {31'b0, mSm ? mLeadD : mLead});
      chk({busOn, masterOn, sampleMode, txPause} == {mBus, mMas, mSm, mPause}, "R10 flags",
          {28'b0, busOn, masterOn, sampleMode, txPause}, {28'b0, mBus, mMas, mSm, mPause});
      chk(regRdata == mRead(regAddr), "R10 readback", regRdata, mRead(regAddr));
    end
  end

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // Measure one SCK period between leading edges and the active time inside it
  task automatic measure(int expPeriod, string tag);
    int n = 0, act = 0, guard = 0;
    do begin tick(); guard++; end while (!sckLead && guard < 5000);
    do begin
      if (sck != sckIdle) act++;
      n++; tick();
    end while (!sckLead && n < 5000);
    chk(n == expPeriod, tag, n, expPeriod);
    chk(act == expPeriod / 2, "R4 active half", act, expPeriod / 2);
  endtask

  localparam logic [31:0] EN = 32'h1, MST = 32'h2, SMP = 32'h4, PAUSE = 32'h80, SRST = 32'h8000_0000;
  localparam logic [31:0] SEL = 32'h1000;

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(sck == sckIdle && !sckLead && !sckTrail && !sampleStb, "R1 outputs idle",
        {28'b0, sck, sckLead, sckTrail, sampleStb}, 32'h0);
    chk({busOn, masterOn, sampleMode, txPause} == 4'b0, "R1 flags clear",
        {28'b0, busOn, masterOn, sampleMode, txPause}, 32'h0);
    chk(regRdata == 32'h0, "R1 control reads zero", regRdata, 32'h0);
    regAddr = 1'b1; #1;
    chk(regRdata == 32'h0, "R1 clock reg reads zero", regRdata, 32'h0);
    modelOn = 1'b1;

    // R5: divider programmed but bus disabled
    wr(1'b1, SEL | 32'd2);
    begin
      int leads = 0, bad = 0;
      for (int i = 0; i < 20; i++) begin
        tick();
        if (sckLead || sckTrail) leads++;
        if (sck != sckIdle) bad++;
      end
      chk(leads == 0 && bad == 0, "R5 held idle while disabled", leads + bad, 0);
    end
    chk(regRdata == (SEL | 32'd2), "R10 clock reg readback", regRdata, SEL | 32'd2);

    // R10: flags without bus enable
    wr(1'b0, MST | PAUSE | SMP | 32'h0000_7F00);
    tick();
    chk(regRdata == (MST | PAUSE | SMP), "R10 unused bits zero", regRdata, MST | PAUSE | SMP);
    chk(masterOn && txPause && sampleMode && !busOn, "R10 flag outputs",
        {28'b0, busOn, masterOn, sampleMode, txPause}, 32'h7);

    // R2: linear law
    wr(1'b0, EN | MST);
    measure(6, "R2 period N=2");
    wr(1'b1, SEL | 32'd0);
    measure(2, "R2 period N=0");
    wr(1'b1, SEL | 32'd255);
    measure(512, "R2 period N=255");

    // R3: power-of-two law
    wr(1'b1, 32'd3 << 8);
    measure(8, "R3 period E=3");
    wr(1'b1, 32'd0 << 8);
    measure(2, "R3 period E=0 clamps");
    wr(1'b1, 32'd1 << 8);
    measure(2, "R3 period E=1");
    wr(1'b1, 32'd10 << 8);
    measure(1024, "R3 period E=10");
    wr(1'b1, 32'd15 << 8);
    measure(1024, "R3 period E=15 saturates");

    // R6: restart on divider write while running
    wr(1'b1, SEL | 32'd3);
    measure(8, "R2 period N=3");
    repeat (5) tick();
    wr(1'b1, SEL | 32'd4);
    tick();
    chk(sck == sckIdle && !sckLead && !sckTrail, "R6 restart idle", {31'b0, sck}, {31'b0, sckIdle});
    begin
      int n = 0;
      while (!sckLead && n < 100) begin tick(); n++; end
      chk(n == 5, "R6 first edge one half-period later", n, 5);
    end

    // R7: soft reset
    repeat (3) tick();
    @(negedge clk);
    regAddr = 1'b0;
    wr(1'b0, SRST | EN | MST);
    #1;
    chk(regRdata[31] == 1'b1, "R7 reset bit visible", regRdata, SRST | EN | MST);
    tick();
    chk(sck == sckIdle && !sckLead, "R7 sck idle after soft reset", {31'b0, sck}, {31'b0, sckIdle});
    chk(regRdata == (EN | MST), "R7 bit self-clears, others kept", regRdata, EN | MST);

    // R9: delayed sample strobe
    wr(1'b0, EN | MST | SMP);
    begin
      int guard = 0;
      while (!sckLead && guard < 100) begin tick(); guard++; end
      chk(!sampleStb, "R9 no sample on lead cycle", {31'b0, sampleStb}, 32'h0);
      tick();
      chk(sampleStb, "R9 sample one cycle later", {31'b0, sampleStb}, 32'h1);
    end
    wr(1'b0, EN | MST);
    begin
      int guard = 0;
      while (!sckLead && guard < 100) begin tick(); guard++; end
      chk(sampleStb, "R9 sample with lead", {31'b0, sampleStb}, 32'h1);
    end

    // Inverted idle level
    wr(1'b0, 32'h0);
    @(negedge clk); sckIdle = 1'b1;
    tick();
    chk(sck == 1'b1, "R5 idle high while disabled", {31'b0, sck}, 32'h1);
    wr(1'b0, EN);
    measure(10, "R2 period N=4 idle high");

    repeat (4) tick();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; total++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule